// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block compares two unsigned operands and reports whether the first is less than, equal to or greater than the second. It is made of identical slices. Each slice looks at one group of operand bits and carries a three-wire relation (less, equal, greater) from the slice below it to the slice above it. By default there are three 4-bit slices, so the operands are 12 bits wide. The lowest slice receives a seed relation on three input pins, and the top slice drives the three result pins. The block is purely combinational and has no clock.

For a standalone comparison, tie the seed pins to less=0, equal=1, greater=0. To extend a wider comparison, drive the seed pins from the result pins of another instance that compares less significant bits. Inside a slice, each bit cell works the same way as a slice. It passes the relation from below unchanged when its two bits match. When they differ, it replaces that relation with its own verdict. The most significant differing bit therefore decides the result.

Top module: `cmp_chain`

## Requirements
- R1: With seed less=0, equal=1, greater=0, the result is res_gt=1 exactly when op_a > op_b, res_lt=1 exactly when op_a < op_b, and res_eq=1 exactly when op_a == op_b, all unsigned.
- R2: Whenever exactly one seed pin is high, exactly one of res_lt, res_eq, res_gt is high.
- R3: Operands that differ only in bit 0 are decided by that bit: res_gt=1 if op_a[0]=1, else res_lt=1.
- R4: When the top slice's bit groups (bits 11..8 by default) differ, the result is the ordering of those groups alone, whatever the lower bits and the seed are.
- R5: When op_a == op_b, the three result pins equal the three seed pins bit for bit, including seeds that are not one-hot.
- R6: res_eq is high only when op_a == op_b and seed_eq is high.
- R7: Slice k compares bits SLICE_W*k+SLICE_W-1 down to SLICE_W*k. A difference in a more significant slice overrides any difference in a less significant slice.
- R8: Parameterized widths give the same ordering behaviour. A 2-slice chain of 2-bit slices matches unsigned 4-bit comparison for every operand pair and every seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 12 (SLICE_W*NUM_SLICES) | First unsigned operand |
| op_b | input | 12 (SLICE_W*NUM_SLICES) | Second unsigned operand |
| seed_lt | input | 1 | Less-than relation fed into the lowest slice |
| seed_eq | input | 1 | Equal relation fed into the lowest slice |
| seed_gt | input | 1 | Greater-than relation fed into the lowest slice |
| res_lt | output | 1 | op_a below op_b |
| res_eq | output | 1 | op_a equals op_b, given an equal seed |
| res_gt | output | 1 | op_a above op_b |

## Verification
Assertions check the following every time the inputs change:
- the result is one-hot whenever the seed is one-hot;
- equal operands pass the seed through;
- with the standard seed, the result matches the unsigned ordering;
- a mismatch in the top bit group decides the result on its own.

Some cases need the bench's chosen stimulus to be visible: a difference only in bit 0, a higher slice overriding an opposite lower-slice difference, non-one-hot seeds reaching the outputs, and the exhaustive sweep of the reduced-width variant.

// File: rtl/cmp_pkg.sv
// Package: shared relation type for the comparator chain.
// Assumes: relation is carried as three independent wires (lt, eq, gt).
package cmp_pkg;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    localparam rel_t REL_NEUTRAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/cmp_bit_cell.sv
// Module: cmp_bit_cell
// One iterative cell. It keeps the incoming relation when its two bits
// match and overrides it with its own ordering when they differ.
// Assumes: combinational use only; no encoding rule on rel_in.
module cmp_bit_cell
    import cmp_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  rel_t rel_in,
    output rel_t rel_out
);

    logic same;
    logic a_above;
    logic a_below;

    // Local bit ordering terms.
    always_comb begin
        same    = ~(a_bit ^ b_bit);
        a_above = a_bit & ~b_bit;
        a_below = ~a_bit & b_bit;
    end

    // Merge the local verdict with the relation from below.
    always_comb begin
        rel_out.gt = a_above | (same & rel_in.gt);
        rel_out.lt = a_below | (same & rel_in.lt);
        rel_out.eq = same & rel_in.eq;
    end

endmodule

// File: rtl/cmp_slice.sv
// Module: cmp_slice
// Compares one SLICE_W-bit group with a chain of bit cells. The chain
// is seeded by the relation from the slice below, and its last cell
// gives the relation handed to the slice above.
// Assumes: bit 0 of each operand group is its least significant bit.
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] grp_a,
    input  logic [SLICE_W-1:0] grp_b,
    input  rel_t               casc_in,
    output rel_t               casc_out
);

    rel_t link [SLICE_W+1];

    // Seed the bit chain from the lower slice.
    always_comb link[0] = casc_in;

    genvar i;
    generate
        for (i = 0; i < SLICE_W; i++) begin : g_bit
            cmp_bit_cell u_cell (
                .a_bit   (grp_a[i]),
                .b_bit   (grp_b[i]),
                .rel_in  (link[i]),
                .rel_out (link[i+1])
            );
        end
    endgenerate

    // Hand the most significant cell's relation upward.
    always_comb casc_out = link[SLICE_W];

endmodule

// File: rtl/cmp_chain.sv
// Module: cmp_chain (top)
// Unsigned magnitude comparator built from NUM_SLICES identical slices.
// Slice 0 takes the seed pins. Each slice feeds the next more
// significant one, and the top slice drives the result pins.
// Assumes: standalone use ties seed to lt=0, eq=1, gt=0.
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              seed_lt,
    input  logic              seed_eq,
    input  logic              seed_gt,
    output logic              res_lt,
    output logic              res_eq,
    output logic              res_gt
);

    rel_t casc [NUM_SLICES+1];

    // Pack the seed pins into the lowest cascade link.
    always_comb casc[0] = '{lt: seed_lt, eq: seed_eq, gt: seed_gt};

    genvar s;
    generate
        for (s = 0; s < NUM_SLICES; s++) begin : g_slice
            cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
                .grp_a    (op_a[s*SLICE_W +: SLICE_W]),
                .grp_b    (op_b[s*SLICE_W +: SLICE_W]),
                .casc_in  (casc[s]),
                .casc_out (casc[s+1])
            );
        end
    endgenerate

    // Drive the result pins from the top slice.
    always_comb begin
        res_lt = casc[NUM_SLICES].lt;
        res_eq = casc[NUM_SLICES].eq;
        res_gt = casc[NUM_SLICES].gt;
    end

endmodule

// File: rtl/cmp_chain_chk.sv
// Module: cmp_chain_chk
// Port-level checker for cmp_chain, attached with bind. The block has
// no clock, so the checks are immediate assertions that are evaluated
// whenever the inputs or outputs change.
// Assumes: comb evaluation has settled before the checks see values.
module cmp_chain_chk #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              seed_lt,
    input logic              seed_eq,
    input logic              seed_gt,
    input logic              res_lt,
    input logic              res_eq,
    input logic              res_gt
);

    logic std_seed;
    logic [SLICE_W-1:0] top_a;
    logic [SLICE_W-1:0] top_b;

    // Derive helper terms from the ports.
    always_comb begin
        std_seed = ~seed_lt & seed_eq & ~seed_gt;
        top_a    = op_a[DATA_W-1 -: SLICE_W];
        top_b    = op_b[DATA_W-1 -: SLICE_W];
    end

    // Check the result pins against the operand ordering.
    always_comb begin
        if ($onehot({seed_lt, seed_eq, seed_gt}))
            AST_ONE_HOT_RESULT: assert ($onehot({res_lt, res_eq, res_gt})); // R2
        if (std_seed)
            AST_STD_ORDER: assert ((res_gt == (op_a > op_b)) && (res_lt == (op_a < op_b))); // R1
        if (op_a == op_b)
            AST_EQUAL_PASS: assert ({res_lt, res_eq, res_gt} == {seed_lt, seed_eq, seed_gt}); // R5
        if (res_eq)
            AST_EQ_ONLY_MATCH: assert ((op_a == op_b) && seed_eq); // R6
        if (top_a != top_b)
            AST_TOP_DECIDES: assert ((res_gt == (top_a > top_b)) && (res_lt == (top_a < top_b)) && !res_eq); // R4
    end

endmodule

bind cmp_chain cmp_chain_chk #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .seed_lt (seed_lt),
    .seed_eq (seed_eq),
    .seed_gt (seed_gt),
    .res_lt  (res_lt),
    .res_eq  (res_eq),
    .res_gt  (res_gt)
);

// File: tb/cmp_chain_tb.sv
// Bench for cmp_chain. It runs a 12-bit instance with random and
// directed vectors, and a reduced 4-bit instance exhaustively.
// Inputs are driven after the rising edge and outputs sampled at the
// falling edge.
module cmp_chain_tb;

    localparam int W_BIG   = 12;
    localparam int W_SMALL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;

    logic [W_BIG-1:0]   a_big, b_big;
    logic [W_SMALL-1:0] a_sm, b_sm;
    logic [2:0]         seed_big, seed_sm;      // {lt, eq, gt}
    logic               lt_big, eq_big, gt_big;
    logic               lt_sm, eq_sm, gt_sm;

    // 200 MHz clock paces the stimulus.
    always #2.5 clk = ~clk;

    cmp_chain #(.SLICE_W(4), .NUM_SLICES(3)) u_dut (
        .op_a (a_big), .op_b (b_big),
        .seed_lt (seed_big[2]), .seed_eq (seed_big[1]), .seed_gt (seed_big[0]),
        .res_lt (lt_big), .res_eq (eq_big), .res_gt (gt_big)
    );

    cmp_chain #(.SLICE_W(2), .NUM_SLICES(2)) u_dut_small (
        .op_a (a_sm), .op_b (b_sm),
        .seed_lt (seed_sm[2]), .seed_eq (seed_sm[1]), .seed_gt (seed_sm[0]),
        .res_lt (lt_sm), .res_eq (eq_sm), .res_gt (gt_sm)
    );

    // Reference model: the unsigned ordering, or the seed on a tie.
    function automatic logic [2:0] exp_rel(input int unsigned a, input int unsigned b,
                                           input logic [2:0] seed);
        if (a > b)      return 3'b001;
        else if (a < b) return 3'b100;
        else            return seed;
    endfunction

    // Count one comparison and report it if it mismatches.
    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp,
                         input int unsigned a, input int unsigned b);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s a=%0h b=%0h actual=%b expected=%b", req, a, b, got, exp);
        end
    endtask

    // Apply one vector to the 12-bit instance and check it at the falling edge.
    task automatic run_big(input string req, input logic [W_BIG-1:0] a,
                           input logic [W_BIG-1:0] b, input logic [2:0] seed);
        @(posedge clk);
        a_big = a; b_big = b; seed_big = seed;
        @(negedge clk);
        check(req, {lt_big, eq_big, gt_big}, exp_rel(a, b, seed), a, b);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Main stimulus sequence.
    initial begin
        int unsigned dummy;
        logic [W_BIG-1:0] ra, rb;
        logic [2:0] rs;
        dummy = $urandom(32'h5EED_1234);
        a_big = '0; b_big = '0; seed_big = 3'b010;
        a_sm  = '0; b_sm  = '0; seed_sm  = 3'b010;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero operands with the neutral seed read as equal (R1).
        check("R1 reset", {lt_big, eq_big, gt_big}, 3'b010, 0, 0);

        // R3: operands that differ only in bit 0.
        run_big("R3", 12'h000, 12'h001, 3'b010);
        run_big("R3", 12'h001, 12'h000, 3'b010);
        run_big("R3", 12'hABE, 12'hABF, 3'b010);
        run_big("R3", 12'hFFF, 12'hFFE, 3'b010);
        // R4: the top group decides, even against the seed and lower bits.
        run_big("R4", 12'h7FF, 12'h800, 3'b001);
        run_big("R4", 12'h900, 12'h8FF, 3'b100);
        // R7: a higher slice overrides an opposite lower-slice difference.
        run_big("R7", 12'h01F, 12'h020, 3'b010);
        run_big("R7", 12'h3F0, 12'h40F, 3'b010);
        run_big("R7", 12'h5A0, 12'h49F, 3'b010);
        // R5: equal operands pass every seed pattern through.
        for (int s = 0; s < 8; s++) begin
            run_big("R5", 12'h5C3, 12'h5C3, 3'(s));
        end
        // R6: equal operands with a low seed_eq never report equal.
        run_big("R6", 12'hFFF, 12'hFFF, 3'b000);
        run_big("R6", 12'h000, 12'h000, 3'b101);
        // R2: one-hot seeds give a one-hot result.
        for (int s = 0; s < 3; s++) begin
            run_big("R2", 12'h123, 12'h123, 3'b001 << s);
            n_checks++;
            if (!$onehot({lt_big, eq_big, gt_big})) begin
                n_errors++;
                $display("FAIL R2 actual=%b expected=one-hot", {lt_big, eq_big, gt_big});
            end
        end

        // R1: random 12-bit operands, mostly the neutral seed, some odd seeds.
        for (int k = 0; k < 3000; k++) begin
            ra = 12'($urandom);
            rb = (k % 7 == 0) ? ra : ((k % 5 == 0) ? (ra ^ 12'(1 << ($urandom % 12))) : 12'($urandom));
            rs = (k % 4 == 0) ? 3'($urandom) : 3'b010;
            run_big("R1", ra, rb, rs);
        end

        // R8: exhaustive sweep of the reduced-width chain.
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    @(posedge clk);
                    a_sm = 4'(x); b_sm = 4'(y); seed_sm = 3'(s);
                    @(negedge clk);
                    check("R8", {lt_sm, eq_sm, gt_sm}, exp_rel(x, y, 3'(s)), x, y);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule